// File: doc/BRIEF.md
# Dual-Rail Reset Supervisor with Hold Timer

This block turns digitized supply-monitor results and a push-button input into two active-low, open-drain reset outputs. The auxiliary reset tracks the auxiliary rail monitor. The main reset combines three causes: the main rail monitor, the manual reset button, and the auxiliary reset. Each output stays asserted for a fixed hold time after the last of its causes goes away. The hold time is set in milliseconds and converted to clock cycles from the clock frequency parameter.

The auxiliary reset pin is bidirectional. The block pulls the pin low through an output enable and reads the pin level back. When something outside pulls the pin low while the block is not driving it, that counts as an auxiliary reset cause. The manual input and the read-back pin are asynchronous, so each passes through a two-flop synchronizer before it is used.

While the main reset is asserted, the block overrides an 8-bit fan speed code. The code goes to full scale if the thermal override input is low, and to zero otherwise. Comparators, thresholds and pull-up resistors sit outside this block.

Top module: `rst_supervisor`

## Requirements
- R1: While `aux_rail_ok_i` is 0 at a rising clock edge, `aux_rst_oe_o` is 1 after that edge.
- R2: While `main_rail_ok_i` is 0 at a rising edge, `main_rst_oe_o` is 1 after that edge. When `aux_rst_oe_o` is 1 at an edge, `main_rst_oe_o` is also 1 after that edge. The main reset therefore releases no earlier than HOLD_CYCLES edges after the auxiliary reset releases.
- R3: A low level on `man_rst_ni` passes through two synchronizer flops and asserts `main_rst_oe_o` on the third rising edge that samples the low level. It has no effect on `aux_rst_oe_o`.
- R4: A low level on `aux_rst_pin_i` while `aux_rst_oe_o` is 0 is synchronized the same way. It asserts `aux_rst_oe_o` on the third edge, and after that it asserts `main_rst_oe_o`.
- R5: Each output releases exactly HOLD_CYCLES rising edges after the last edge at which one of its causes was present. If a cause returns during the hold, the hold count starts again from zero.
- R6: While `main_rst_oe_o` is 0, `fan_code_o` equals `fan_code_i`. While it is 1, `fan_code_o` is 8'h00 if `therm_ni` is 1 and 8'hFF if `therm_ni` is 0.
- R7: While `rst_ni` is low, both outputs are 1 and the synchronizers are cleared. After `rst_ni` rises with no cause present, `aux_rst_oe_o` releases after HOLD_CYCLES edges and `main_rst_oe_o` releases HOLD_CYCLES edges after that.
- R8: The block's own low drive on the auxiliary pin, read back through `aux_rst_pin_i`, never counts as an external cause. The auxiliary reset therefore does not keep itself asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| main_rail_ok_i | input | 1 | Main rail monitor, 1 = above threshold |
| aux_rail_ok_i | input | 1 | Auxiliary rail monitor, 1 = above threshold |
| man_rst_ni | input | 1 | Manual reset, active low; tie high if unused |
| aux_rst_pin_i | input | 1 | Level read back from the auxiliary reset pin |
| therm_ni | input | 1 | Thermal override, active low |
| fan_code_i | input | 8 | Fan speed code used in normal operation |
| aux_rst_oe_o | output | 1 | Pull-down enable for the auxiliary reset pin |
| main_rst_oe_o | output | 1 | Pull-down enable for the main reset pin |
| fan_code_o | output | 8 | Fan speed code after the reset override |

## Verification
Assertions check on every cycle that a failing rail asserts its output on the next edge. They also check that the auxiliary reset drags the main reset along, that the manual input reaches the main reset after the synchronizer delay, and that a hold counter never releases an output at an edge where a cause was present and never counts past its limit. The exact hold length, the restart of the count when a cause comes back, the masking of the block's own pin drive, and the fan override values with the thermal input high and low are shown by the bench. The bench compares the ports against a cycle-level reference model in directed scenarios and in a long random run.

// File: rtl/rst_sup_pkg.sv
package rst_sup_pkg;
  localparam int unsigned FAN_W = 8;
  typedef logic [FAN_W-1:0] fan_code_t;

  localparam fan_code_t FAN_IDLE_CODE = '0;
  localparam fan_code_t FAN_FULL_CODE = '1;

  function automatic int unsigned hold_cycles(input int unsigned clk_khz,
                                              input int unsigned hold_ms);
    int unsigned n;
    n = clk_khz * hold_ms;
    return (n == 0) ? 1 : n;
  endfunction
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rst_hold_timer.sv
module rst_hold_timer #(
  parameter int unsigned HOLD_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cause_i,
  output logic active_o
);
  localparam int unsigned CNT_W = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (cause_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (active_q) begin
      if (cnt_q == LAST) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign active_o = active_q;

  p_no_release_on_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_q) |-> !$past(cause_i));
  p_restart_on_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_i |=> (active_q && cnt_q == '0));
  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  p_idle_cnt_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> cnt_q == '0);
endmodule

// File: rtl/fan_override.sv
module fan_override
  import rst_sup_pkg::*;
(
  input  logic      force_i,
  input  logic      therm_ni,
  input  fan_code_t code_i,
  output fan_code_t code_o
);
  always_comb begin
    if (!force_i)      code_o = code_i;
    else if (!therm_ni) code_o = FAN_FULL_CODE;
    else               code_o = FAN_IDLE_CODE;
  end
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
  import rst_sup_pkg::*;
#(
  parameter int unsigned CLK_KHZ     = 25000,
  parameter int unsigned HOLD_MS     = 180,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            main_rail_ok_i,
  input  logic            aux_rail_ok_i,
  input  logic            man_rst_ni,
  input  logic            aux_rst_pin_i,
  input  logic            therm_ni,
  input  logic [FAN_W-1:0] fan_code_i,
  output logic            aux_rst_oe_o,
  output logic            main_rst_oe_o,
  output logic [FAN_W-1:0] fan_code_o
);
  localparam int unsigned HOLD_CYCLES = hold_cycles(CLK_KHZ, HOLD_MS);

  logic man_req;
  logic ext_aux_raw, ext_aux_req;
  logic aux_cause, main_cause;
  logic aux_act, main_act;

  rst_sync #(.STAGES(SYNC_STAGES)) i_man_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(!man_rst_ni), .q_o(man_req)
  );

  // Own pull-down reads back as low: mask it so the line cannot latch itself.
  assign ext_aux_raw = !aux_rst_pin_i && !aux_act;

  rst_sync #(.STAGES(SYNC_STAGES)) i_ext_aux_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ext_aux_raw), .q_o(ext_aux_req)
  );

  assign aux_cause  = !aux_rail_ok_i || ext_aux_req;
  assign main_cause = !main_rail_ok_i || man_req || aux_act;

  rst_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) i_aux_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .cause_i(aux_cause), .active_o(aux_act)
  );

  rst_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) i_main_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .cause_i(main_cause), .active_o(main_act)
  );

  fan_override i_fan (
    .force_i(main_act), .therm_ni(therm_ni), .code_i(fan_code_i), .code_o(fan_code_o)
  );

  assign aux_rst_oe_o  = aux_act;
  assign main_rst_oe_o = main_act;

  p_aux_rail_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !aux_rail_ok_i |=> aux_rst_oe_o);
  p_main_rail_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !main_rail_ok_i |=> main_rst_oe_o);
  p_main_follows_aux_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aux_rst_oe_o |=> main_rst_oe_o);
  p_manual_latency_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni, 3) && $past(rst_ni, 2) && $past(!man_rst_ni, 3)) |-> main_rst_oe_o);
endmodule

// File: tb/test_rst_supervisor.sv
module test_rst_supervisor;
  import rst_sup_pkg::*;

  localparam time CLK_PERIOD = 10ns;
  localparam int unsigned HOLD = 12;
  localparam int unsigned WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic main_ok = 1'b1, aux_ok = 1'b1, man_n = 1'b1, ext_low = 1'b0, therm_n = 1'b1;
  logic [7:0] fan_in = 8'h5A;
  logic aux_oe, main_oe;
  logic [7:0] fan_out;
  logic aux_pin;

  int n_tests = 0, n_fail = 0;
  int cycles = 0;

  assign aux_pin = !(aux_oe || ext_low);

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_supervisor #(.CLK_KHZ(1), .HOLD_MS(HOLD), .SYNC_STAGES(2)) i_rst_supervisor (
    .clk_i(clk), .rst_ni(rst_n), .main_rail_ok_i(main_ok), .aux_rail_ok_i(aux_ok),
    .man_rst_ni(man_n), .aux_rst_pin_i(aux_pin), .therm_ni(therm_n),
    .fan_code_i(fan_in), .aux_rst_oe_o(aux_oe), .main_rst_oe_o(main_oe),
    .fan_code_o(fan_out)
  );

  // reference model state
  logic [1:0] m_ms = '0, m_as = '0;
  logic m_aux = 1'b1, m_main = 1'b1;
  int   m_aux_cnt = 0, m_main_cnt = 0;

  function automatic logic [7:0] exp_fan(input logic forced, input logic th_n,
                                         input logic [7:0] code);
    if (!forced) return code;
    return th_n ? 8'h00 : 8'hFF;
  endfunction

  task automatic timer_step(inout logic act, inout int cnt, input logic cause);
    if (cause) begin act = 1'b1; cnt = 0; end
    else if (act) begin
      if (cnt == HOLD - 1) begin act = 1'b0; cnt = 0; end
      else cnt = cnt + 1;
    end
  endtask

  task automatic model_edge();
    logic aux_c, main_c, pre_aux;
    if (!rst_n) begin
      m_ms = '0; m_as = '0; m_aux = 1'b1; m_main = 1'b1; m_aux_cnt = 0; m_main_cnt = 0;
    end else begin
      pre_aux = m_aux;
      aux_c  = !aux_ok || m_as[1];
      main_c = !main_ok || m_ms[1] || pre_aux;
      m_ms = {m_ms[0], !man_n};
      m_as = {m_as[0], ext_low && !pre_aux};
      timer_step(m_aux, m_aux_cnt, aux_c);
      timer_step(m_main, m_main_cnt, main_c);
    end
  endtask

  task automatic check(input string tag, input string what, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", tag, what, got, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    check(tag, "aux_rst_oe", aux_oe, m_aux);
    check(tag, "main_rst_oe", main_oe, m_main);
    check(tag, "fan_code", fan_out, exp_fan(m_main, therm_n, fan_in));
  endtask

  // One clock: edge, model update, compare at the falling edge.
  task automatic step(input string tag);
    @(posedge clk);
    #1;
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic steps(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin : watchdog
    while (cycles < WATCHDOG) begin
      @(posedge clk);
      cycles++;
    end
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion earlier", cycles);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : stim
    int rel;
    void'($urandom(32'd1234));

    // R7: reset state
    repeat (3) @(negedge clk);
    check("R7", "aux in reset", aux_oe, 1);
    check("R7", "main in reset", main_oe, 1);
    check("R7", "fan in reset", fan_out, 8'h00);
    rst_n = 1'b1;
    rel = 0;
    while (aux_oe) begin step("R7"); rel++; end
    check("R7", "aux release edges", rel, HOLD);
    rel = 0;
    while (main_oe) begin step("R2"); rel++; end
    check("R2", "main after aux edges", rel, HOLD);
    check("R6", "fan passthrough", fan_out, 8'h5A);

    // R1: aux rail dip pulls both
    aux_ok = 1'b0;
    step("R1");
    check("R1", "aux asserted", aux_oe, 1);
    aux_ok = 1'b1;
    step("R2");
    check("R2", "main follows aux", main_oe, 1);
    steps(2 * HOLD + 4, "R5");

    // R3: manual reset, aux untouched
    man_n = 1'b0;
    steps(2, "R3");
    check("R3", "main before sync done", main_oe, 0);
    step("R3");
    check("R3", "main after sync", main_oe, 1);
    check("R3", "aux unaffected", aux_oe, 0);
    man_n = 1'b1;
    steps(HOLD + 4, "R3");
    check("R3", "main released", main_oe, 0);

    // R4: external pull on aux pin
    ext_low = 1'b1;
    steps(2, "R4");
    check("R4", "aux before sync done", aux_oe, 0);
    step("R4");
    check("R4", "aux after sync", aux_oe, 1);
    ext_low = 1'b0;
    step("R4");
    check("R4", "main follows external", main_oe, 1);
    steps(2 * HOLD + 6, "R8");
    check("R8", "aux not self-held", aux_oe, 0);
    check("R8", "main released", main_oe, 0);

    // R5: restart when cause returns mid-hold
    main_ok = 1'b0; step("R5"); main_ok = 1'b1;
    steps(HOLD / 2, "R5");
    main_ok = 1'b0; step("R5"); main_ok = 1'b1;
    rel = 0;
    while (main_oe) begin step("R5"); rel++; end
    check("R5", "restarted hold edges", rel, HOLD);

    // R6: thermal override during main reset
    therm_n = 1'b0;
    main_ok = 1'b0; step("R6");
    check("R6", "fan full on", fan_out, 8'hFF);
    therm_n = 1'b1; #1;
    check("R6", "fan idle", fan_out, 8'h00);
    main_ok = 1'b1;
    steps(HOLD + 2, "R6");

    // R7: mid-run asynchronous reset
    rst_n = 1'b0; #1;
    check("R7", "async aux", aux_oe, 1);
    check("R7", "async main", main_oe, 1);
    step("R7");
    rst_n = 1'b1;
    steps(2 * HOLD + 2, "R7");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      main_ok = ($urandom_range(0, 39) != 0);
      aux_ok  = ($urandom_range(0, 79) != 0);
      man_n   = ($urandom_range(0, 59) != 0);
      ext_low = ($urandom_range(0, 89) == 0);
      therm_n = ($urandom_range(0, 3) != 0);
      fan_in  = 8'($urandom);
      if ($urandom_range(0, 1999) == 0) rst_n = 1'b0;
      else rst_n = 1'b1;
      #1;
      step("R5");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule